// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This unit collects interrupt requests from one dedicated external interrupt pin and from sixteen general-purpose pins. The dedicated pin has a selectable sense: a held low level, a falling edge, a rising edge, or any change. The general-purpose pins form two groups of eight. Each group has its own per-pin mask, and a toggle in either direction on any unmasked pin of a group latches that group's flag. The unit senses pad values, not the output drivers. Software can therefore raise an interrupt by driving a pin that is configured as an output.

All pins pass through a two-flop synchronizer. The clocked detectors compare each synchronized value with the value sampled one cycle earlier. A separate combinational wake path compares the raw pads against that last sampled value. While the clock is halted the sampled value does not move, so any unmasked change keeps the wake output high until the clock runs again. A low level on the dedicated pin produces a request only while the synchronized level is still low. It never latches a flag.

Software reaches the unit through a small register port with four registers: two masks, one control register and one flag register. The request outputs go to the interrupt controller. The acknowledge inputs clear the matching flags when an interrupt is taken.

Top module: `ext_pin_irq_unit`

## Requirements
- R1: After reset, every register reads 0 and `req_ext`, `req_grp` and `wake_req` are low. The register addresses are: 0 = group 0 mask, 1 = group 1 mask, 2 = control, 3 = flags. Any other address reads 0.
- R2: With control bits [1:0] = 10 (falling) and control bit 2 (dedicated-pin enable) set, a 1-to-0 transition on `ext_pin` sets flag bit 0. The flag is set on the third rising clock edge after the change, and `req_ext` follows it.
- R3: With sense 11 (rising), only a 0-to-1 transition on `ext_pin` sets flag bit 0. A 1-to-0 transition leaves it clear.
- R4: With sense 00 (low level) and the enable set, `req_ext` is high exactly while the synchronized `ext_pin` is low. It rises two edges after the pin falls and drops two edges after the pin rises. Flag bit 0 is never set in this mode.
- R5: A change in either direction on a group 0 pin (`gp_pins[7:0]`) whose bit is set in the group 0 mask sets flag bit 1. Changes on masked-off pins, and on group 1 pins, leave it clear. `req_grp[0]` is flag bit 1 ANDed with control bit 3.
- R6: Group 1 (`gp_pins[15:8]`) works the same way. It uses its own mask, flag bit 2 and control bit 4, and drives `req_grp[1]`.
- R7: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves the flag unchanged.
- R8: A one-cycle pulse on `ack_ext` or on `ack_grp[g]` clears the matching flag.
- R9: If a flag is set and cleared in the same cycle, the flag ends up set.
- R10: With an enable bit clear, the matching flag still latches events, but its request output stays low.
- R11: With the clock halted, a change on an unmasked pin of an enabled group raises `wake_req` combinationally. A change on a masked pin does not.
- R12: With the clock halted in low-level mode, `wake_req` follows the raw low level. If the level returns high before the clock restarts, no request and no flag result.
- R13: With sense 01 (any change), transitions in both directions on `ext_pin` set flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Dedicated interrupt pad, asynchronous |
| gp_pins | input | 16 | General-purpose pads, asynchronous; [7:0] group 0, [15:8] group 1 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| ack_ext | input | 1 | Acknowledge, clears flag bit 0 |
| ack_grp | input | 2 | Per-group acknowledge, clears flag bit 1+g |
| req_ext | output | 1 | Dedicated-pin interrupt request |
| req_grp | output | 2 | Group interrupt requests |
| wake_req | output | 1 | Clock-independent wake request |

## Verification
The dedicated pin is driven through both transition directions in each sense mode. This shows that the falling, rising and any-change decoders are distinct, and that low-level mode follows the pin without latching. Group pins are toggled high and low on masked and unmasked positions in both groups, which separates the per-pin mask from the group selection. Clears are tried by write-one, by write-zero and by acknowledge, and once in the exact cycle a set arrives, which tells set-wins from clear-wins. With the bench clock stopped, pad changes show that the wake path is independent of the clock and obeys the masks. A low pulse that ends before the clock restarts shows wake without a request.

// File: rtl/eip_pkg.sv
package eip_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int CTRL_SENSE_LSB = 0;
  localparam int CTRL_EXT_EN    = 2;
  localparam int CTRL_GRP_EN0   = 3;

  // clocked or raw edge decode against the previous sampled level
  function automatic logic edge_hit(sense_e m, logic prev, logic cur);
    case (m)
      SENSE_ANY:  return prev ^ cur;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic level_low(sense_e m, logic cur);
    return (m == SENSE_LOW) && !cur;
  endfunction

endpackage

// File: rtl/eip_sync.sv
module eip_sync #(
  parameter int W      = 17,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eip_regs.sv
module eip_regs
  import eip_pkg::*;
#(
  parameter int NUM_GRP = 2,
  parameter int GRP_W   = 8,
  parameter int AW      = 3,
  parameter int DW      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic [NUM_GRP:0]       flag_q,
  output logic [GRP_W*NUM_GRP-1:0] mask_q,
  output sense_e                 sense_q,
  output logic                   ext_en_q,
  output logic [NUM_GRP-1:0]     grp_en_q,
  output logic [NUM_GRP:0]       flag_w1c,
  output logic [DW-1:0]          rdata
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_GRP);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(NUM_GRP + 1);
  localparam int            NF        = NUM_GRP + 1;

  logic [DW-1:0] ctrl_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
    localparam logic [AW-1:0] MY_ADDR = AW'(g);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        mask_q[g*GRP_W +: GRP_W] <= '0;
      else if (wr_en && addr == MY_ADDR)
        mask_q[g*GRP_W +: GRP_W] <= wdata[GRP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          ctrl_q <= '0;
    else if (wr_en && addr == CTRL_ADDR) ctrl_q <= wdata;

  assign sense_q  = sense_e'(ctrl_q[CTRL_SENSE_LSB +: 2]);
  assign ext_en_q = ctrl_q[CTRL_EXT_EN];
  assign grp_en_q = ctrl_q[CTRL_GRP_EN0 +: NUM_GRP];

  assign flag_w1c = (wr_en && addr == FLAG_ADDR) ? wdata[NF-1:0] : '0;

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (addr == AW'(g)) rdata[GRP_W-1:0] = mask_q[g*GRP_W +: GRP_W];
    if (addr == CTRL_ADDR) rdata = ctrl_q;
    if (addr == FLAG_ADDR) rdata[NF-1:0] = flag_q;
  end
endmodule

// File: rtl/eip_flag.sv
module eip_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set has priority so an event in the clearing cycle survives
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
endmodule

// File: rtl/eip_ext_det.sv
module eip_ext_det
  import eip_pkg::*;
(
  input  sense_e sense,
  input  logic   en,
  input  logic   prev,
  input  logic   cur,
  input  logic   raw,
  output logic   hit,
  output logic   lvl_low,
  output logic   wake
);
  assign hit     = edge_hit(sense, prev, cur);
  assign lvl_low = level_low(sense, cur);
  assign wake    = en & (level_low(sense, raw) | edge_hit(sense, prev, raw));
endmodule

// File: rtl/eip_grp_det.sv
module eip_grp_det #(
  parameter int GRP_W = 8
) (
  input  logic             en,
  input  logic [GRP_W-1:0] mask,
  input  logic [GRP_W-1:0] prev,
  input  logic [GRP_W-1:0] cur,
  input  logic [GRP_W-1:0] raw,
  output logic             hit,
  output logic             wake
);
  assign hit  = |((cur ^ prev) & mask);
  assign wake = en & (|((raw ^ prev) & mask));
endmodule

// File: rtl/ext_pin_irq_unit.sv
module ext_pin_irq_unit
  import eip_pkg::*;
#(
  parameter int GRP_W       = 8,
  parameter int NUM_GRP     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3,
  parameter int DW          = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_pin,
  input  logic [GRP_W*NUM_GRP-1:0] gp_pins,
  input  logic                     reg_wr_en,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic                     ack_ext,
  input  logic [NUM_GRP-1:0]       ack_grp,
  output logic                     req_ext,
  output logic [NUM_GRP-1:0]       req_grp,
  output logic                     wake_req
);
  localparam int PIN_W     = GRP_W * NUM_GRP;
  localparam int SW        = PIN_W + 1;
  localparam int NUM_FLAGS = NUM_GRP + 1;

  logic [SW-1:0] raw_all, sync_all, prev_all;
  logic          ext_s, ext_prev;

  logic [PIN_W-1:0]     mask_q;
  sense_e               sense_q;
  logic                 ext_en_q;
  logic [NUM_GRP-1:0]   grp_en_q;
  logic [NUM_FLAGS-1:0] flag_w1c, flag_set, flag_clr, flag_q;

  logic                 ext_hit, ext_lvl_low, ext_wake;
  logic [NUM_GRP-1:0]   grp_hit, grp_wake;

  assign raw_all = {ext_pin, gp_pins};

  eip_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_all), .q(sync_all)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_all <= '0;
    else        prev_all <= sync_all;

  assign ext_s    = sync_all[PIN_W];
  assign ext_prev = prev_all[PIN_W];

  eip_regs #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .flag_q(flag_q), .mask_q(mask_q), .sense_q(sense_q),
    .ext_en_q(ext_en_q), .grp_en_q(grp_en_q),
    .flag_w1c(flag_w1c), .rdata(reg_rdata)
  );

  eip_ext_det u_ext (
    .sense(sense_q), .en(ext_en_q), .prev(ext_prev), .cur(ext_s),
    .raw(ext_pin), .hit(ext_hit), .lvl_low(ext_lvl_low), .wake(ext_wake)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    eip_grp_det #(.GRP_W(GRP_W)) u_det (
      .en(grp_en_q[g]),
      .mask(mask_q[g*GRP_W +: GRP_W]),
      .prev(prev_all[g*GRP_W +: GRP_W]),
      .cur(sync_all[g*GRP_W +: GRP_W]),
      .raw(gp_pins[g*GRP_W +: GRP_W]),
      .hit(grp_hit[g]),
      .wake(grp_wake[g])
    );
  end

  assign flag_set = {grp_hit, ext_hit};
  assign flag_clr = flag_w1c | {ack_grp, ack_ext};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    eip_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(flag_set[i]), .clr(flag_clr[i]), .q(flag_q[i])
    );
  end

  assign req_ext  = ext_en_q & (ext_lvl_low | ((sense_q != SENSE_LOW) & flag_q[0]));
  assign req_grp  = grp_en_q & flag_q[NUM_FLAGS-1:1];
  assign wake_req = ext_wake | (|grp_wake);
endmodule

// File: rtl/eip_checker.sv
module eip_checker #(
  parameter int NUM_GRP   = 2,
  parameter int NUM_FLAGS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           sense,
  input logic                 ext_en,
  input logic                 ext_lvl,
  input logic [NUM_GRP-1:0]   grp_en,
  input logic [NUM_FLAGS-1:0] flag_set,
  input logic [NUM_FLAGS-1:0] flag_clr,
  input logic [NUM_FLAGS-1:0] flag_q,
  input logic                 req_ext,
  input logic [NUM_GRP-1:0]   req_grp
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_fl
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[i] |=> flag_q[i]);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !flag_set[i]) |=> !flag_q[i]);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_clr[i] && !flag_set[i]) |=> (flag_q[i] == $past(flag_q[i])));
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_rq
    p_grp_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_grp[g] |-> (flag_q[g+1] && grp_en[g]));
  end

  p_no_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == 2'b00) |-> !flag_set[0]);
  p_low_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ext && sense == 2'b00) |-> !ext_lvl);
  p_ext_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ext |-> ext_en);
endmodule

bind ext_pin_irq_unit eip_checker #(.NUM_GRP(NUM_GRP), .NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sense(sense_q), .ext_en(ext_en_q),
  .ext_lvl(ext_s), .grp_en(grp_en_q), .flag_set(flag_set),
  .flag_clr(flag_clr), .flag_q(flag_q), .req_ext(req_ext), .req_grp(req_grp)
);

// File: tb/tb_ext_pin_irq_unit.sv
module tb_ext_pin_irq_unit;
  logic        clk = 1'b0;
  bit          clk_run = 1'b1;
  logic        rst_n;
  logic        ext_pin;
  logic [15:0] gp_pins;
  logic        reg_wr_en;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        ack_ext;
  logic [1:0]  ack_grp;
  logic        req_ext;
  logic [1:0]  req_grp;
  logic        wake_req;

  always #5 if (clk_run) clk = ~clk;

  ext_pin_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .gp_pins(gp_pins),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_ext(ack_ext), .ack_grp(ack_grp),
    .req_ext(req_ext), .req_grp(req_grp), .wake_req(wake_req)
  );

  typedef struct {
    string       tag;
    logic [11:0] exp;
    logic [11:0] care;
  } exp_t;

  localparam logic [11:0] C_ALL  = 12'hFFF;
  localparam logic [11:0] C_NOWK = 12'h7FF;
  localparam logic [11:0] C_REQ  = 12'h700;
  localparam logic [11:0] C_WK   = 12'h800;
  localparam logic [11:0] C_WREQ = 12'hF00;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  wire [11:0] obs = {wake_req, req_ext, req_grp[1], req_grp[0], reg_rdata};

  function automatic exp_t mk(string tag, logic w, logic e, logic g1, logic g0,
                              logic [7:0] rd, logic [11:0] care);
    exp_t it;
    it.tag  = tag;
    it.exp  = {w, e, g1, g0, rd};
    it.care = care;
    return it;
  endfunction

  task automatic cmp(exp_t it);
    n_chk++;
    if ((obs & it.care) !== (it.exp & it.care)) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (care %h)", it.tag, obs & it.care,
               it.exp & it.care, it.care);
    end
  endtask

  task automatic push(exp_t it);
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) cmp(sb.pop_front());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 3'd3;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_pin = 1'b1; gp_pins = '0;
    reg_wr_en = 1'b0; reg_addr = 3'd3; reg_wdata = '0;
    ack_ext = 1'b0; ack_grp = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    push(mk("R1 flags/outputs", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1); reg_addr = 3'd0;
    push(mk("R1 mask0", 0, 0, 0, 0, 8'h00, C_NOWK));
    idle(1); reg_addr = 3'd2;
    push(mk("R1 ctrl", 0, 0, 0, 0, 8'h00, C_NOWK));
    idle(1); reg_addr = 3'd5;
    push(mk("R1 unused addr", 0, 0, 0, 0, 8'h00, C_NOWK));
    idle(1); reg_addr = 3'd3;

    // R2 falling edge, exact latency
    wr(3'd2, 8'h06);
    idle(3);
    push(mk("R2 idle", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    ext_pin = 1'b0;
    push(mk("R2 edge+1", 1, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    push(mk("R2 edge+2", 1, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    push(mk("R2 edge+3", 0, 1, 0, 0, 8'h01, C_ALL));
    idle(1);
    ext_pin = 1'b1;
    idle(4);
    push(mk("R2 rise ignored, flag kept", 0, 1, 0, 0, 8'h01, C_NOWK));
    idle(1);

    // R7 write zero keeps, write one clears
    wr(3'd3, 8'h00);
    push(mk("R7 write0 no effect", 0, 1, 0, 0, 8'h01, C_NOWK));
    wr(3'd3, 8'h01);
    push(mk("R7 write1 clears", 0, 0, 0, 0, 8'h00, C_NOWK));
    idle(1);

    // R3 rising edge only
    wr(3'd2, 8'h07);
    ext_pin = 1'b0;
    idle(5);
    push(mk("R3 fall ignored", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    ext_pin = 1'b1;
    idle(5);
    push(mk("R3 rise sets", 0, 1, 0, 0, 8'h01, C_ALL));
    idle(1);

    // R8 acknowledge clears
    ack_ext = 1'b1;
    idle(1);
    ack_ext = 1'b0;
    push(mk("R8 ack_ext clears", 0, 0, 0, 0, 8'h00, C_NOWK));
    idle(1);

    // R10 enable off: flag latches, no request, no wake
    wr(3'd2, 8'h03);
    ext_pin = 1'b0;
    idle(5);
    ext_pin = 1'b1;
    push(mk("R10 no wake when disabled", 0, 0, 0, 0, 8'h00, C_WREQ));
    idle(5);
    push(mk("R10 flag set, req low", 0, 0, 0, 0, 8'h01, C_ALL));
    wr(3'd3, 8'h01);

    // R13 any change
    wr(3'd2, 8'h05);
    ext_pin = 1'b0;
    idle(5);
    push(mk("R13 fall sets", 0, 1, 0, 0, 8'h01, C_NOWK));
    wr(3'd3, 8'h01);
    ext_pin = 1'b1;
    idle(5);
    push(mk("R13 rise sets", 0, 1, 0, 0, 8'h01, C_NOWK));
    wr(3'd3, 8'h01);

    // R4 low level
    wr(3'd2, 8'h04);
    idle(4);
    push(mk("R4 high idle", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    ext_pin = 1'b0;
    push(mk("R4 low+1", 1, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    push(mk("R4 low+2 req", 1, 1, 0, 0, 8'h00, C_ALL));
    idle(4);
    push(mk("R4 held low, no flag", 1, 1, 0, 0, 8'h00, C_ALL));
    idle(1);
    ext_pin = 1'b1;
    push(mk("R4 high+1 still req", 0, 1, 0, 0, 8'h00, C_ALL));
    idle(1);
    push(mk("R4 high+2 drops", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1);

    // R5 group 0 masks, both directions
    wr(3'd0, 8'h0A);
    reg_addr = 3'd0;
    push(mk("R5 mask0 readback", 0, 0, 0, 0, 8'h0A, C_NOWK));
    idle(1); reg_addr = 3'd3;
    wr(3'd2, 8'h08);
    gp_pins[0] = 1'b1;
    push(mk("R5 masked pin no wake", 0, 0, 0, 0, 8'h00, C_WK));
    idle(1);
    gp_pins[9] = 1'b1;
    idle(5);
    push(mk("R5 masked/other group ignored", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    gp_pins[3] = 1'b1;
    push(mk("R5 rise+1", 1, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    push(mk("R5 rise+2", 1, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    push(mk("R5 rise+3 sets", 0, 0, 0, 1, 8'h02, C_ALL));
    wr(3'd3, 8'h02);
    gp_pins[3] = 1'b0;
    idle(5);
    push(mk("R5 fall sets", 0, 0, 0, 1, 8'h02, C_ALL));
    wr(3'd3, 8'h02);

    // R6 group 1
    wr(3'd1, 8'h80);
    wr(3'd2, 8'h10);
    gp_pins[8] = 1'b1;
    idle(5);
    push(mk("R6 masked pin8 ignored", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    gp_pins[15] = 1'b1;
    idle(5);
    push(mk("R6 pin15 sets grp1", 0, 0, 1, 0, 8'h04, C_ALL));
    idle(1);
    ack_grp = 2'b10;
    idle(1);
    ack_grp = 2'b00;
    push(mk("R8 ack_grp clears", 0, 0, 0, 0, 8'h00, C_NOWK));
    idle(1);

    // R9 set and clear in the same cycle
    gp_pins[15] = 1'b0;
    idle(2);
    reg_wr_en = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h04;
    idle(1);
    reg_wr_en = 1'b0;
    push(mk("R9 set wins", 0, 0, 1, 0, 8'h04, C_NOWK));
    wr(3'd3, 8'h04);
    idle(2);

    // R11 wake with halted clock
    wr(3'd2, 8'h18);
    idle(3);
    clk_run = 1'b0;
    #20;
    cmp(mk("R11 halted idle", 0, 0, 0, 0, 8'h00, C_WREQ));
    gp_pins[0] = 1'b0;
    #5;
    cmp(mk("R11 masked change no wake", 0, 0, 0, 0, 8'h00, C_WREQ));
    gp_pins[1] = 1'b1;
    #5;
    cmp(mk("R11 unmasked change wakes", 1, 0, 0, 0, 8'h00, C_WREQ));
    clk_run = 1'b1;
    idle(5);
    push(mk("R11 request after restart", 0, 0, 0, 1, 8'h02, C_ALL));
    wr(3'd3, 8'h02);

    // R12 low level vanishes before restart
    wr(3'd2, 8'h04);
    idle(3);
    clk_run = 1'b0;
    #20;
    ext_pin = 1'b0;
    #5;
    cmp(mk("R12 raw low wakes", 1, 0, 0, 0, 8'h00, C_WREQ));
    ext_pin = 1'b1;
    #5;
    cmp(mk("R12 level gone", 0, 0, 0, 0, 8'h00, C_WREQ));
    clk_run = 1'b1;
    @(negedge clk);
    push(mk("R12 no req +1", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(1);
    push(mk("R12 no req +2", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(3);
    push(mk("R12 no req/flag", 0, 0, 0, 0, 8'h00, C_ALL));
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule